// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block runs single accesses on an external asynchronous static-RAM style device on behalf of an internal requester. The requester offers a word address, write data and a direction flag with `req_valid`. When the controller is idle it takes the request, drives chip select, address, data and one of the two strobes through three timed phases (setup, strobe, hold), and then gives a one-cycle `req_ready` pulse. For a read, the captured data is on `req_rdata` in that cycle.

Reads and writes each have their own setup, strobe and hold lengths. A mode bit limits chip select to the strobe phase only. Another bit lets the external wait line stretch the strobe phase. A width bit selects either a 16-bit bus or an 8-bit bus on the low lane. The device occupies a window of internal word addresses that starts at `BASE_ADDR` (default 0x00100000). That address maps to external word 0. A request outside the window completes at once and causes no external activity.

Top module: `async_mem_ctrl`

## Requirements
- R1: A setup count s, strobe count t and hold count h give s+1, t+1 and h+1 cycles. The first setup cycle is the cycle after the clock edge that accepts the request. Reads use the `cfg_rd_*` counts and writes use the `cfg_wr_*` counts.
- R2: A write pulls `mem_we_n` low during the strobe phase only, and a read does the same with `mem_oe_n`. The two are never low together.
- R3: With `cfg_sel_strobe`=0, `mem_cs_n` is low in every setup, strobe and hold cycle. With `cfg_sel_strobe`=1, it is low only in strobe cycles.
- R4: With `cfg_ext_wait`=1, each clock edge in the strobe phase with `mem_wait` high adds one strobe cycle. With `cfg_ext_wait`=0, `mem_wait` has no effect on any output.
- R5: A write sets `mem_dq_oe` high from the first setup cycle to the last hold cycle, with the write data held steady on `mem_dq_out`. A read never sets `mem_dq_oe`.
- R6: A read samples `mem_dq_in` at the edge that ends the last strobe cycle. The value appears on `req_rdata` in the `req_ready` cycle and stays there until the next read.
- R7: With `cfg_asize`=1 the bus is 16 bits wide. With `cfg_asize`=0 only bits 7:0 carry data: `mem_dq_out[15:8]` is driven 0 and `req_rdata[15:8]` reads 0.
- R8: `mem_addr` equals `req_addr - BASE_ADDR` (word address, 20 bits) for the whole access. 0x00100000 gives 0 and 0x001FFFFF gives 0xFFFFF.
- R9: `req_ready` is high for one cycle, the cycle after the last hold cycle, and all pins are idle then. `req_valid` is only taken while idle, and a request raised during an access is dropped with no effect.
- R10: A request whose address is outside the window gives `req_ready` in the following cycle and leaves all memory pins idle.
- R11: The configuration is captured when a request is accepted. Changing it during the access has no effect on that access.
- R12: In reset, and afterwards until a request, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high and `mem_dq_oe` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Internal word address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Last read data |
| cfg_rd_setup | input | 6 | Read setup count (cycles minus one) |
| cfg_rd_strobe | input | 6 | Read strobe count (cycles minus one) |
| cfg_rd_hold | input | 6 | Read hold count (cycles minus one) |
| cfg_wr_setup | input | 6 | Write setup count (cycles minus one) |
| cfg_wr_strobe | input | 6 | Write strobe count (cycles minus one) |
| cfg_wr_hold | input | 6 | Write hold count (cycles minus one) |
| cfg_sel_strobe | input | 1 | Chip select only during strobe |
| cfg_ext_wait | input | 1 | Let mem_wait stretch the strobe |
| cfg_asize | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 20 | External word address |
| mem_dq_in | input | 16 | Data from the device |
| mem_dq_out | output | 16 | Data to the device |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_wait | input | 1 | Device wait request, active high |

## Verification
The bench goes after the phase boundaries. It measures setup, strobe and hold lengths from the pins, with zero counts and with read counts that differ from write counts, so a design that shares one set of counts or is off by one cycle fails the length checks. The device model returns a value that changes in every strobe cycle, so a controller that samples early or late returns the wrong word. Wait pulses are applied with stretching enabled and disabled, which catches a design that freezes on the wrong edge or does not ignore the line when disabled. Further tests change the configuration during an access, raise a request during an access, use the 8-bit mode and use an address outside the window. These expose a controller that does not capture its settings at acceptance, that starts a second access, that leaks the upper byte, or that touches the pins for an address it does not own.

// File: rtl/amc_pkg.sv
package amc_pkg;

    parameter int AMC_DATA_W = 16;
    parameter int AMC_EXT_AW = 20;
    parameter int AMC_CNT_W  = 6;
    parameter int AMC_LANE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } amc_phase_e;

    typedef struct packed {
        logic [AMC_CNT_W-1:0] setup;
        logic [AMC_CNT_W-1:0] strobe;
        logic [AMC_CNT_W-1:0] hold;
    } amc_timing_t;

    typedef struct packed {
        logic                  write;
        logic [AMC_EXT_AW-1:0] addr;
        logic [AMC_DATA_W-1:0] wdata;
        amc_timing_t           tim;
        logic                  sel_strobe;
        logic                  wait_en;
        logic                  wide;
    } amc_access_t;

    function automatic amc_timing_t pick_timing(input logic is_write,
                                                input amc_timing_t rd,
                                                input amc_timing_t wr);
        return is_write ? wr : rd;
    endfunction

    function automatic logic [AMC_DATA_W-1:0] lane_mask(input logic [AMC_DATA_W-1:0] d,
                                                        input logic wide);
        logic [AMC_DATA_W-1:0] m;
        m = d;
        if (!wide) m[AMC_DATA_W-1:AMC_LANE_W] = '0;
        return m;
    endfunction

endpackage

// File: rtl/amc_sequencer.sv
module amc_sequencer
    import amc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  amc_timing_t tim,
    input  logic        wait_en,
    input  logic        wait_in,
    output amc_phase_e  phase,
    output logic        last_strobe,
    output logic        done
);

    logic [AMC_CNT_W-1:0] cnt;
    logic                 cnt_zero;
    logic                 stall;

    always_comb begin
        cnt_zero    = (cnt == '0);
        stall       = wait_en && wait_in && (phase == PH_STROBE);
        last_strobe = (phase == PH_STROBE) && cnt_zero && !stall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        cnt   <= tim.setup;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase <= PH_STROBE;
                        cnt   <= tim.strobe;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (!stall) begin
                        if (cnt_zero) begin
                            phase <= PH_HOLD;
                            cnt   <= tim.hold;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                PH_HOLD: begin
                    if (cnt_zero) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/amc_pin_drive.sv
module amc_pin_drive
    import amc_pkg::*;
#(
    parameter int LANES = AMC_DATA_W / AMC_LANE_W
)(
    input  amc_phase_e             phase,
    input  logic                   is_write,
    input  logic                   sel_strobe,
    input  logic                   wide,
    input  logic [AMC_DATA_W-1:0]  wdata,
    output logic                   cs_n,
    output logic                   oe_n,
    output logic                   we_n,
    output logic                   dq_oe,
    output logic [AMC_DATA_W-1:0]  dq_out
);

    logic busy;
    logic in_strobe;

    always_comb begin
        busy      = (phase != PH_IDLE);
        in_strobe = (phase == PH_STROBE);
        cs_n      = !(busy && (!sel_strobe || in_strobe));
        we_n      = !(in_strobe && is_write);
        oe_n      = !(in_strobe && !is_write);
        dq_oe     = busy && is_write;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_on;
        assign lane_on = dq_oe && ((g == 0) || wide);
        assign dq_out[g*AMC_LANE_W +: AMC_LANE_W] =
            lane_on ? wdata[g*AMC_LANE_W +: AMC_LANE_W] : '0;
    end

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
    import amc_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0010_0000
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [AMC_DATA_W-1:0]  req_wdata,
    output logic                   req_ready,
    output logic [AMC_DATA_W-1:0]  req_rdata,
    input  logic [AMC_CNT_W-1:0]   cfg_rd_setup,
    input  logic [AMC_CNT_W-1:0]   cfg_rd_strobe,
    input  logic [AMC_CNT_W-1:0]   cfg_rd_hold,
    input  logic [AMC_CNT_W-1:0]   cfg_wr_setup,
    input  logic [AMC_CNT_W-1:0]   cfg_wr_strobe,
    input  logic [AMC_CNT_W-1:0]   cfg_wr_hold,
    input  logic                   cfg_sel_strobe,
    input  logic                   cfg_ext_wait,
    input  logic                   cfg_asize,
    output logic                   mem_cs_n,
    output logic                   mem_oe_n,
    output logic                   mem_we_n,
    output logic [AMC_EXT_AW-1:0]  mem_addr,
    input  logic [AMC_DATA_W-1:0]  mem_dq_in,
    output logic [AMC_DATA_W-1:0]  mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic                   mem_wait
);

    localparam int HI_W = ADDR_W - AMC_EXT_AW;

    amc_phase_e             phase;
    amc_access_t            acc_q;
    amc_timing_t            rd_tim, wr_tim, cfg_tim, tim_live;
    logic [ADDR_W-1:0]      offset;
    logic                   in_window;
    logic                   accept, start;
    logic                   last_strobe, seq_done, miss_q;
    logic                   sel_q;
    logic [AMC_DATA_W-1:0]  rdata_q;

    always_comb begin
        offset    = req_addr - BASE_ADDR;
        in_window = (offset[ADDR_W-1 -: HI_W] == '0);
        accept    = req_valid && (phase == PH_IDLE);
        start     = accept && in_window;
        rd_tim    = '{setup: cfg_rd_setup, strobe: cfg_rd_strobe, hold: cfg_rd_hold};
        wr_tim    = '{setup: cfg_wr_setup, strobe: cfg_wr_strobe, hold: cfg_wr_hold};
        cfg_tim   = pick_timing(req_write, rd_tim, wr_tim);
        tim_live  = (phase == PH_IDLE) ? cfg_tim : acc_q.tim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            rdata_q <= '0;
            miss_q  <= 1'b0;
        end else begin
            miss_q <= accept && !in_window;
            if (start) begin
                acc_q.write      <= req_write;
                acc_q.addr       <= offset[AMC_EXT_AW-1:0];
                acc_q.wdata      <= req_wdata;
                acc_q.tim        <= cfg_tim;
                acc_q.sel_strobe <= cfg_sel_strobe;
                acc_q.wait_en    <= cfg_ext_wait;
                acc_q.wide       <= cfg_asize;
            end
            if (last_strobe && !acc_q.write)
                rdata_q <= lane_mask(mem_dq_in, acc_q.wide);
        end
    end

    amc_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .tim         (tim_live),
        .wait_en     (acc_q.wait_en),
        .wait_in     (mem_wait),
        .phase       (phase),
        .last_strobe (last_strobe),
        .done        (seq_done)
    );

    assign sel_q = acc_q.sel_strobe;

    amc_pin_drive u_pins (
        .phase      (phase),
        .is_write   (acc_q.write),
        .sel_strobe (sel_q),
        .wide       (acc_q.wide),
        .wdata      (acc_q.wdata),
        .cs_n       (mem_cs_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .dq_oe      (mem_dq_oe),
        .dq_out     (mem_dq_out)
    );

    assign mem_addr  = acc_q.addr;
    assign req_ready = seq_done | miss_q;
    assign req_rdata = rdata_q;

endmodule

// File: rtl/amc_checks.sv
module amc_checks
    import amc_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  cs_n,
    input logic                  oe_n,
    input logic                  we_n,
    input logic                  dq_oe,
    input logic [AMC_DATA_W-1:0] dq_out,
    input logic                  ready,
    input logic                  sel_q
);

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));

    assert_strobe_inside_cs_R3: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !oe_n) |-> !cs_n);

    assert_cs_only_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_q && !cs_n) |-> (!we_n || !oe_n));

    assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !dq_oe);

    assert_wdata_steady_R5: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

    assert_ready_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cs_n && oe_n && we_n && !dq_oe));

endmodule

bind async_mem_ctrl amc_checks u_amc_checks (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (mem_cs_n),
    .oe_n   (mem_oe_n),
    .we_n   (mem_we_n),
    .dq_oe  (mem_dq_oe),
    .dq_out (mem_dq_out),
    .ready  (req_ready),
    .sel_q  (sel_q)
);

// File: tb/sim_async_mem_ctrl.sv
`timescale 1ns/1ps
module sim_async_mem_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic [15:0] req_rdata;
    logic [5:0]  rs = 6'd2, rt = 6'd3, rh = 6'd2;
    logic [5:0]  ws = 6'd2, wt = 6'd3, wh = 6'd2;
    logic        sel = 1'b0, ew = 1'b0, wide = 1'b1;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_wait;
    logic [19:0] mem_addr;
    logic [15:0] mem_dq_in, mem_dq_out;

    int n_chk  = 0;
    int n_fail = 0;
    int st_cyc = 0;
    int wait_left = 0;

    always #10 clk = ~clk;

    async_mem_ctrl u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
        .cfg_rd_setup(rs), .cfg_rd_strobe(rt), .cfg_rd_hold(rh),
        .cfg_wr_setup(ws), .cfg_wr_strobe(wt), .cfg_wr_hold(wh),
        .cfg_sel_strobe(sel), .cfg_ext_wait(ew), .cfg_asize(wide),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_wait(mem_wait)
    );

    // device model: data changes every strobe cycle; wait from 2nd strobe cycle
    logic strobing;
    assign strobing  = !mem_we_n || !mem_oe_n;
    assign mem_wait  = strobing && (st_cyc >= 1) && (wait_left > 0);
    assign mem_dq_in = !mem_oe_n ? ((mem_addr[15:0] ^ 16'h5A00) ^ st_cyc[15:0]) : 16'hFFFF;

    always @(posedge clk) begin
        st_cyc <= strobing ? st_cyc + 1 : 0;
        if (mem_wait) wait_left <= wait_left - 1;
    end

    typedef struct {
        bit          wr;
        bit          miss;
        logic [19:0] addr;
        logic [15:0] bus_wd;
        logic [15:0] rd_exp;
        bit          sel;
        int          pre;
        int          stb;
        int          post;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // monitor
    int m_cyc = 0, m_pre = 0, m_stb = 0, m_post = 0;
    bit e_cs = 0, e_dir = 0, e_oe = 0, e_addr = 0, e_wd = 0;

    task automatic clear_mon();
        m_cyc = 0; m_pre = 0; m_stb = 0; m_post = 0;
        e_cs = 0; e_dir = 0; e_oe = 0; e_addr = 0; e_wd = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (sbq.size() == 0) begin
                if (!mem_cs_n || !mem_oe_n || !mem_we_n || mem_dq_oe || req_ready)
                    chk(0, "R9 stray activity with no request pending",
                        {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11100);
            end else begin
                exp_t it;
                it = sbq[0];
                m_cyc++;
                if (it.miss) begin
                    chk(req_ready === 1'b1, {"R10 ready after out-of-window ", it.tag}, req_ready, 1);
                    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe,
                        {"R10 pins idle ", it.tag},
                        {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
                    void'(sbq.pop_front());
                    clear_mon();
                end else if (req_ready) begin
                    chk(m_pre == it.pre, {"R1 setup cycles ", it.tag}, m_pre, it.pre);
                    chk(m_stb == it.stb, {"R1 strobe cycles (R4 wait) ", it.tag}, m_stb, it.stb);
                    chk(m_post == it.post, {"R1 hold cycles ", it.tag}, m_post, it.post);
                    chk(!e_dir, {"R2 strobe pin choice ", it.tag}, e_dir, 0);
                    chk(!e_cs, {"R3 chip select shape ", it.tag}, e_cs, 0);
                    chk(!e_oe, {"R5 bus drive enable ", it.tag}, e_oe, 0);
                    chk(!e_addr, {"R8 external address ", it.tag}, e_addr, 0);
                    if (it.wr)
                        chk(!e_wd, {"R5 R7 write data on bus ", it.tag}, e_wd, 0);
                    else
                        chk(req_rdata === it.rd_exp, {"R6 R7 read data ", it.tag}, req_rdata, it.rd_exp);
                    chk(mem_cs_n && !mem_dq_oe, {"R9 idle in ready cycle ", it.tag},
                        {mem_cs_n, mem_dq_oe}, 2'b10);
                    void'(sbq.pop_front());
                    clear_mon();
                end else begin
                    bit s;
                    s = strobing;
                    if (s) m_stb++;
                    else if (m_stb == 0) m_pre++;
                    else m_post++;
                    if (mem_cs_n !== (it.sel ? !s : 1'b0)) e_cs = 1;
                    if (it.wr ? !mem_oe_n : !mem_we_n) e_dir = 1;
                    if (mem_dq_oe !== it.wr) e_oe = 1;
                    if (mem_addr !== it.addr) e_addr = 1;
                    if (it.wr && mem_dq_out !== it.bus_wd) e_wd = 1;
                    if (m_cyc > 2000) begin
                        chk(0, {"R9 ready never came ", it.tag}, m_cyc, 0);
                        void'(sbq.pop_front());
                        clear_mon();
                    end
                end
            end
        end
    end

    // driver
    task automatic issue(input bit wr, input logic [31:0] a, input logic [15:0] wd,
                         input int waits, input bit chg_cfg, input bit poke, input string tag);
        exp_t it;
        int s, t, h, nst;
        logic [15:0] key;
        s = wr ? int'(ws) : int'(rs);
        t = wr ? int'(wt) : int'(rt);
        h = wr ? int'(wh) : int'(rh);
        it.wr     = wr;
        it.miss   = (a < 32'h0010_0000) || (a >= 32'h0020_0000);
        it.addr   = 20'(a - 32'h0010_0000);
        it.bus_wd = wide ? wd : {8'h00, wd[7:0]};
        nst       = t + 1 + (ew ? waits : 0);
        key       = it.addr[15:0] ^ 16'h5A00;
        it.rd_exp = key ^ 16'(nst - 1);
        if (!wide) it.rd_exp[15:8] = 8'h00;
        it.sel  = sel;
        it.pre  = s + 1;
        it.stb  = nst;
        it.post = h + 1;
        it.tag  = tag;
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        wait_left = waits;
        @(posedge clk); #2;
        req_valid = 1'b0;
        sbq.push_back(it);
        if (chg_cfg) begin
            sel = !sel; ew = !ew; wide = !wide;
            rs = rs + 6'd3; rt = rt + 6'd2; rh = rh + 6'd1;
            ws = ws + 6'd1; wt = wt + 6'd4; wh = wh + 6'd2;
        end
        if (poke) begin
            @(posedge clk); #2;
            req_valid = 1'b1; req_write = !wr; req_addr = a + 32'd7;
            @(posedge clk); #2;
            req_valid = 1'b0;
        end
        for (int g = 0; g < 3000 && sbq.size() != 0; g++) @(negedge clk);
    endtask

    task automatic set_rd(input int s, input int t, input int h);
        rs = 6'(s); rt = 6'(t); rh = 6'(h);
    endtask

    task automatic set_wr(input int s, input int t, input int h);
        ws = 6'(s); wt = 6'(t); wh = 6'(h);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready,
            "R12 pins after reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11100);
        repeat (3) @(negedge clk);
        chk(mem_cs_n && !mem_dq_oe, "R12 idle without request", {mem_cs_n, mem_dq_oe}, 2'b10);

        // R1 R2 R5 R8: write at window base, full-width select
        set_wr(2, 3, 2); set_rd(2, 3, 2);
        issue(1, 32'h0010_0000, 16'h1234, 0, 0, 0, "T1 write base");
        issue(0, 32'h0010_0123, 16'h0000, 0, 0, 0, "T2 read");
        // R3 select-strobe mode, zero counts
        sel = 1; set_wr(0, 0, 0);
        issue(1, 32'h0010_0042, 16'hCAFE, 0, 0, 0, "T3 write sel-strobe zero counts");
        set_rd(1, 4, 3);
        issue(0, 32'h001F_FFFF, 16'h0000, 0, 0, 0, "T4 read top of window");
        // R4 wait stretching enabled and disabled
        sel = 0; ew = 1; set_rd(1, 2, 1);
        issue(0, 32'h0010_0A00, 16'h0000, 3, 0, 0, "T5 read wait enabled");
        ew = 0;
        issue(0, 32'h0010_0A01, 16'h0000, 3, 0, 0, "T6 read wait ignored R4");
        ew = 1; set_wr(1, 2, 1);
        issue(1, 32'h0010_0B00, 16'h5AA5, 2, 0, 0, "T7 write wait enabled");
        // R7 narrow bus
        ew = 0; wide = 0;
        issue(1, 32'h0010_0C00, 16'hBEEF, 0, 0, 0, "T8 narrow write R7");
        issue(0, 32'h0010_3C77, 16'h0000, 0, 0, 0, "T9 narrow read R7");
        wide = 1;
        // R1 independent read and write counts under one setting
        set_rd(1, 5, 0); set_wr(3, 1, 2);
        issue(1, 32'h0010_0D00, 16'h0F0F, 0, 0, 0, "T10 write own counts R1");
        issue(0, 32'h0010_0D00, 16'h0000, 0, 0, 0, "T11 read own counts R1");
        // R11 config change mid-access, R9 request during access dropped
        set_rd(3, 3, 3); set_wr(3, 3, 3); sel = 0; ew = 0; wide = 1;
        issue(0, 32'h0010_0E00, 16'h0000, 2, 1, 1, "T12 cfg change R11 and busy request R9");
        set_rd(3, 3, 3); set_wr(3, 3, 3); sel = 0; ew = 0; wide = 1;
        issue(1, 32'h0010_0E10, 16'h9876, 2, 1, 1, "T13 cfg change R11 on write");
        sel = 0; ew = 0; wide = 1;
        // R10 outside the window
        issue(0, 32'h0020_0000, 16'h0000, 0, 0, 0, "T14 above window");
        issue(1, 32'h000F_FFFF, 16'h1111, 0, 0, 0, "T15 below window");
        // R6 read data held until next read
        set_rd(0, 1, 0);
        issue(0, 32'h0010_0777, 16'h0000, 0, 0, 0, "T16 read");
        issue(1, 32'h0010_0778, 16'h2222, 0, 0, 0, "T17 write after read");
        chk(req_rdata === ((16'h0777 ^ 16'h5A00) ^ 16'd1), "R6 read data kept across write",
            req_rdata, (16'h0777 ^ 16'h5A00) ^ 16'd1);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule